// File: doc/BRIEF.md
# I2C Output-Enable Control Slave

This block is the control port of a clock fan-out buffer. It listens on a two-wire serial bus that runs at up to 100 kbit/s. It oversamples the SCL and SDA lines with a faster system clock. When it sees a write frame for its own address, it acknowledges the frame and moves the payload into a small bank of output-enable registers. There is one enable line for each differential output pair. The feedback pair has an enable line too, and that line is always on.

A write frame begins with the address byte. Two bytes follow it, and both are acknowledged and then dropped: a command code first, then a byte count. After those, data bytes fill the enable registers strictly in order, starting at the first register. A register cannot be addressed directly. A STOP or a repeated START puts the sequencer back to the start of the frame, so the next data byte lands in the first register again. The slave only receives. It never stretches SCL and never returns data.

Top module: `clkbuf_oe_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one ends the current frame. A repeated START begins a new frame whose first data byte goes to register 0.
- R2: Only the address byte 0xD2 is accepted, which is 7-bit address 1101001 with the R/W bit at 0. Any other address, including 0xD3 with the read bit set, gets no acknowledge. The bus is then ignored, with no register changes, until the next START.
- R3: The address byte and every byte after it in an accepted frame are acknowledged. The block pulls SDA low from the SCL falling edge that ends bit 8 until the SCL falling edge that ends the ninth pulse.
- R4: The first byte after the address is a command code. It is acknowledged and has no effect on any enable.
- R5: The second byte after the address is a byte count. It is acknowledged and has no effect on any enable.
- R6: The third byte after the address loads register 0 and the fourth loads register 1. Any later bytes in the same frame are acknowledged and discarded.
- R7: Register 0 bit 7 down to bit 0 enable pairs 0 to 7 in that order. Register 1 bit 7 enables pair 8 and bit 6 enables pair 9. Register 1 bits 5 to 0 have no effect. A 1 enables a pair and a 0 disables it.
- R8: After reset every pair enable is 1.
- R9: The feedback pair enable `fb_en_o` is 1 at all times.
- R10: Bits travel most significant bit first and are sampled on the SCL rising edge.
- R11: A STOP in the middle of a byte discards the partial byte, and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| pair_en_o | output | NUM_PAIRS | Enable for each output pair, 1 = enabled |
| fb_en_o | output | 1 | Enable for the feedback pair, always 1 |

## Verification
The assertions check the cycle-level rules on every cycle. A START always leaves the receiver at bit 0 of a new byte. The acknowledge pull only starts while SCL is low and always ends on the SCL fall that follows it. A rejected frame never pulls SDA. The command byte, the count byte and any bytes past the last register never change the enable bank. Only the bench's frames can show what the bytes add up to at the ports. Those frames check the exact bit-to-pair mapping, that a repeated START starts again at the first register, that wrong-address and read frames are ignored, and that a byte cut short by STOP is dropped. The bench compares these against a model of the enable state on every clock.

// File: rtl/oe_ctrl_pkg.sv
package oe_ctrl_pkg;
  localparam int BYTE_W = 8;
  localparam int HDR_BYTES = 2;  // command byte and count byte ahead of the data

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sync_q, scl_sync_d;
  logic [SYNC_STAGES-1:0] sda_sync_q, sda_sync_d;
  logic scl_prev_q, sda_prev_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign scl_sync_d = {scl_sync_q[MSB-1:0], scl_i};
      assign sda_sync_d = {sda_sync_q[MSB-1:0], sda_i};
    end else begin : g_single
      assign scl_sync_d = scl_i;
      assign sda_sync_d = sda_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= scl_sync_d;
      sda_sync_q <= sda_sync_d;
      scl_prev_q <= scl_sync_q[MSB];
      sda_prev_q <= sda_sync_q[MSB];
    end
  end

  assign scl_s_o    = scl_sync_q[MSB];
  assign sda_s_o    = sda_sync_q[MSB];
  assign scl_rise_o = scl_s_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_s_o & scl_prev_q;
  assign start_o    = scl_s_o & scl_prev_q & sda_prev_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_prev_q & ~sda_prev_q & sda_s_o;
endmodule

// File: rtl/byte_engine.sv
module byte_engine
  import oe_ctrl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hD2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start,
  input  logic              stop,
  output logic              sda_pull_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_t         state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              first_q, first_d;
  logic              pull_q, pull_d;
  logic              stb_q, stb_d;

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    first_d  = first_q;
    pull_d   = pull_q;
    stb_d    = 1'b0;
    if (start) begin
      state_d  = ST_RECV;
      bitcnt_d = '0;
      first_d  = 1'b1;
      pull_d   = 1'b0;
    end else if (stop) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise && bitcnt_q != FULL) begin
            shift_d  = {shift_q[BYTE_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == FULL) begin
            if (first_q && shift_q != DEV_ADDR) begin
              state_d = ST_SKIP;
            end else begin
              state_d = ST_ACK;
              pull_d  = 1'b1;
              stb_d   = ~first_q;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d  = ST_RECV;
            bitcnt_d = '0;
            first_d  = 1'b0;
            pull_d   = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      first_q  <= 1'b1;
      pull_q   <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      first_q  <= first_d;
      pull_q   <= pull_d;
      stb_q    <= stb_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign byte_stb_o = stb_q;
  assign byte_o     = shift_q;

  // R1: a START always opens a fresh byte
  a_r1_start_fresh_byte: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q == ST_RECV && bitcnt_q == '0 && first_q));
  // R3: the acknowledge pull begins only while SCL is low
  a_r3_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_s);
  // R3: the acknowledge pull is released on the closing SCL fall
  a_r3_pull_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && scl_fall && !start && !stop) |=> !pull_q);
  // R2: a rejected frame never pulls SDA
  a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !pull_q);
endmodule

// File: rtl/enable_regs.sv
module enable_regs
  import oe_ctrl_pkg::*;
#(
  parameter int NUM_PAIRS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_rst,
  input  logic                 byte_stb,
  input  logic [BYTE_W-1:0]    byte_i,
  output logic [NUM_PAIRS-1:0] pair_en_o
);
  localparam int NUM_REGS = (NUM_PAIRS + BYTE_W - 1) / BYTE_W;
  localparam int LAST_IDX = HDR_BYTES + NUM_REGS;
  localparam int PTR_W    = $clog2(LAST_IDX + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(LAST_IDX);
  localparam logic [PTR_W-1:0] PTR_HDR = PTR_W'(HDR_BYTES);

  logic [PTR_W-1:0]           ptr_q, ptr_d;
  logic [NUM_REGS*BYTE_W-1:0] bank_q;

  always_comb begin
    ptr_d = ptr_q;
    if (frame_rst) ptr_d = '0;
    else if (byte_stb && ptr_q != PTR_END) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  genvar g, p;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic ld;
      assign ld = byte_stb && !frame_rst && (ptr_q == PTR_W'(HDR_BYTES + g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bank_q[g*BYTE_W +: BYTE_W] <= '1;
        else if (ld) bank_q[g*BYTE_W +: BYTE_W] <= byte_i;
      end
    end
    for (p = 0; p < NUM_PAIRS; p++) begin : g_map
      assign pair_en_o[p] = bank_q[(p / BYTE_W) * BYTE_W + (BYTE_W - 1 - (p % BYTE_W))];
    end
  endgenerate

  // R4 / R5: command and count bytes leave the bank untouched
  a_r5_header_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && ptr_q < PTR_HDR) |=> $stable(bank_q));
  // R6: bytes beyond the last register are discarded
  a_r6_overflow_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && ptr_q == PTR_END) |=> $stable(bank_q));
  // R1: frame boundary rewinds the pointer
  a_r1_pointer_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> (ptr_q == '0));
endmodule

// File: rtl/clkbuf_oe_slave.sv
module clkbuf_oe_slave
  import oe_ctrl_pkg::*;
#(
  parameter int                NUM_PAIRS   = 10,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'hD2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull_o,
  output logic [NUM_PAIRS-1:0] pair_en_o,
  output logic                 fb_en_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic byte_stb;
  logic [BYTE_W-1:0] rx_byte;

  bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start     (start),
    .stop      (stop),
    .sda_pull_o(sda_pull_o),
    .byte_stb_o(byte_stb),
    .byte_o    (rx_byte)
  );

  enable_regs #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .frame_rst(start | stop),
    .byte_stb (byte_stb),
    .byte_i   (rx_byte),
    .pair_en_o(pair_en_o)
  );

  assign fb_en_o = 1'b1;  // R9: feedback pair is never gated
endmodule

// File: tb/clkbuf_oe_slave_bench.sv
module clkbuf_oe_slave_bench;
  localparam int NP = 10;
  localparam int Q  = 10;  // clocks per quarter SCL period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_b = 1'b1;
  logic sda_pull;
  logic fb_en;
  logic [NP-1:0] pair_en;
  wire sda_line = sda_b & ~sda_pull;

  always #10 clk = ~clk;

  clkbuf_oe_slave u_clkbuf_oe_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .pair_en_o(pair_en), .fb_en_o(fb_en)
  );

  int vectors = 0;
  int fails = 0;
  int skip = 0;
  bit done = 0;

  logic [7:0] m_reg0 = 8'hFF, m_reg1 = 8'hFF;
  bit m_addr_phase = 0, m_addressed = 0;
  int m_idx = 0;
  bit exp_ack;

  function automatic logic [NP-1:0] model_en();
    logic [NP-1:0] e;
    for (int p = 0; p < NP; p++)
      e[p] = (p < 8) ? m_reg0[7-p] : m_reg1[15-p];
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R7 mapping, R9 feedback)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (skip > 0) skip--;
      else begin
        chk("R7", 32'(pair_en), 32'(model_en()));
        chk("R9", 32'(fb_en), 32'd1);
      end
    end
  end

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic commit(logic [7:0] v);
    if (m_addr_phase) begin
      m_addr_phase = 0;
      m_addressed = (v == 8'hD2);
      exp_ack = m_addressed;
      m_idx = 0;
    end else if (m_addressed) begin
      exp_ack = 1;
      if (m_idx == 2) m_reg0 = v;
      else if (m_idx == 3) m_reg1 = v;
      if (m_idx < 4) m_idx++;
    end else exp_ack = 0;
    skip = 8;
  endtask

  task automatic bus_start();
    sda_b = 1; wclk(Q); scl = 1; wclk(Q);
    sda_b = 0; wclk(Q); scl = 0; wclk(Q);
    m_addr_phase = 1; m_addressed = 0;
  endtask

  task automatic bus_stop();
    sda_b = 0; wclk(Q); scl = 1; wclk(Q); sda_b = 1; wclk(Q);
    m_addr_phase = 0; m_addressed = 0;
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_b = v[i]; wclk(Q); scl = 1; wclk(2*Q);
      if (i == 0) commit(v);
      scl = 0; wclk(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] v);
    send_bits(v, 8);
    sda_b = 1; wclk(Q); scl = 1; wclk(Q);
    if (exp_ack) chk("R3 ack", 32'(sda_pull), 32'd1);
    else         chk("R2 no-ack", 32'(sda_pull), 32'd0);
    wclk(Q); scl = 0; wclk(Q);
  endtask

  initial begin
    wclk(3);
    chk("R8 reset", 32'(pair_en), 32'h3FF);
    chk("R9 reset", 32'(fb_en), 32'd1);
    rst_n = 1; wclk(5);
    chk("R8 after release", 32'(pair_en), 32'h3FF);

    // plain frame: header bytes then both registers
    bus_start(); send_byte(8'hD2); send_byte(8'h55);
    chk("R4 command ignored", 32'(pair_en), 32'h3FF);
    send_byte(8'h02);
    chk("R5 count ignored", 32'(pair_en), 32'h3FF);
    send_byte(8'hA5); send_byte(8'h3C); bus_stop();
    // reg0 A5 -> pairs 0..7 = 1,0,1,0,0,1,0,1 ; reg1 3C -> pair8=0 pair9=0
    chk("R6 both registers", 32'(pair_en), 32'h0A5);

    // wrong address and read bit
    bus_start(); send_byte(8'hD4); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h00); bus_stop();
    chk("R2 foreign address", 32'(pair_en), 32'h0A5);
    bus_start(); send_byte(8'hD3); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h00); bus_stop();
    chk("R2 read bit", 32'(pair_en), 32'h0A5);

    // overflow bytes and reserved bits
    bus_start(); send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h80); send_byte(8'h7F); send_byte(8'h00); send_byte(8'h11);
    bus_stop();
    chk("R10 msb first", 32'(pair_en[7:0]), 32'h01);
    chk("R7 pair8 off pair9 on", 32'(pair_en[9:8]), 32'h2);
    chk("R6 overflow dropped", 32'(pair_en), 32'h201);

    // repeated start rewinds pointer
    bus_start(); send_byte(8'hD2); send_byte(8'h01); send_byte(8'h01);
    send_byte(8'hF0);
    bus_start(); send_byte(8'hD2); send_byte(8'h01); send_byte(8'h01);
    send_byte(8'h12); bus_stop();
    // reg0 12 -> pair3 and pair6 on
    chk("R1 repeated start", 32'(pair_en), 32'h248);

    // partial byte cut by STOP
    bus_start(); send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
    send_bits(8'hFF, 4); bus_stop();
    chk("R11 partial byte", 32'(pair_en), 32'h248);
    bus_start(); send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'hFF); send_byte(8'hC0); bus_stop();
    chk("R1 frame after stop", 32'(pair_en), 32'h3FF);

    wclk(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule